// File: doc/BRIEF.md
# Periodic Interrupt Generator

This block turns a 32.768 kHz tick into periodic interrupt events. A 4-bit rate code picks the period as a power-of-two number of ticks, and an enable bit gates the events. Both inputs come from control registers that are held outside this block. The period is not timed from the last register write. The block keeps a free-running 15-bit tick counter and fires whenever that counter reaches a multiple of the selected period, so events stay on a fixed grid of the time base.

Each event raises two sticky flags: a periodic flag and a combined interrupt-request flag. It also drives the interrupt line. A status read clears both flags and drops the line. When a new event and a read fall in the same cycle, the event wins.

The rate code and the enable are combinational inputs to the event logic. A change to either one applies from the next tick, with no restart of any count.

Top module: `periodic_irq_gen`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the tick counter is cleared to zero. `irq`, `irq_flag` and `periodic_flag` are all low after reset.
- R2: The 15-bit tick counter advances by one on every clock edge where `tick_32k` is high. It wraps from 32767 to 0. It holds its value on every other edge.
- R3: For rate codes 3 to 15, events are spaced 2^(code-1) ticks apart.
- R4: Rate code 1 gives the same period as code 8 (128 ticks). Rate code 2 gives the same period as code 9 (256 ticks).
- R5: Rate code 0 produces no events, whatever `periodic_en` is.
- R6: While `periodic_en` is low, no event occurs, but the tick counter keeps advancing. Enabling again keeps alignment to that counter.
- R7: An event happens on a tick that brings the counter to a multiple of the current period. A change of rate code or enable applies from the next tick, with no restart.
- R8: An event sets `periodic_flag` and `irq_flag` at the clock edge that samples the tick. `irq` follows `irq_flag`.
- R9: Both flags, and `irq` with them, stay set until a `status_rd` pulse. The edge that samples `status_rd` clears them, unless R10 applies.
- R10: When an event and `status_rd` coincide at the same edge, both flags end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable, once per 32.768 kHz period |
| rate_code | input | 4 | Period select, 0 = off |
| periodic_en | input | 1 | Periodic event enable |
| status_rd | input | 1 | Status read pulse; clears flags |
| irq | output | 1 | Interrupt request line, active high |
| irq_flag | output | 1 | Combined request flag (status bit 7) |
| periodic_flag | output | 1 | Periodic flag (status bit 6) |

## Verification
Every result is due one clock after its stimulus. The bench drives `tick_32k` or `status_rd` at a falling edge. The next rising edge registers the flags, and the bench samples them at the falling edge after that. The bench keeps its own count of ticks since reset and derives the expected event for each tick from that count and the period rule. This is how alignment is checked after a rate change, after a disabled stretch and across the counter wrap. A separate latency check confirms that the flags are still low while the tick is pending.

// File: rtl/periodic_irq_pkg.sv
// Shared constants and the rate-code remap for the periodic interrupt generator.
// Assumes rate codes are 4 bits and the counter runs from a 32.768 kHz tick.
package periodic_irq_pkg;
    localparam int CNT_W      = 15;
    localparam int RATE_W     = 4;
    localparam int REMAP_MAX  = 2;
    localparam int REMAP_OFS  = 7;

    // Effective code: low non-zero codes are shifted up by REMAP_OFS.
    function automatic logic [RATE_W:0] eff_code(input logic [RATE_W-1:0] code);
        logic [RATE_W:0] e;
        e = {1'b0, code};
        if (code != '0 && int'(code) <= REMAP_MAX)
            e = e + (RATE_W+1)'(REMAP_OFS);
        return e;
    endfunction
endpackage

// File: rtl/pig_free_counter.sv
// Free-running tick counter. Advances once per tick_en cycle and wraps
// at 2**CNT_W. Assumes tick_en is a single-cycle enable.
module pig_free_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);
    // Count ticks; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick_en)
            count <= count + CNT_W'(1);
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count == $past(count) + CNT_W'(1));
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));
endmodule

// File: rtl/pig_rate_map.sv
// Maps a rate code and enable to an alignment mask over the tick counter.
// The mask has (eff_code-1) low ones. active is low for code 0 or when disabled.
module pig_rate_map
    import periodic_irq_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int RW = RATE_W
) (
    input  logic [RW-1:0] code,
    input  logic          enable,
    output logic          active,
    output logic [CW-1:0] mask
);
    localparam int SHW = RW + 1;

    logic [SHW-1:0] eff;
    logic [SHW-1:0] shift;

    // Remap the code and derive the mask width.
    always_comb begin
        eff    = eff_code(code);
        shift  = (eff == '0) ? '0 : eff - SHW'(1);
        active = enable && (code != '0);
    end

    // One mask bit per counter bit, set below the shift amount.
    for (genvar i = 0; i < CW; i++) begin : g_mask
        assign mask[i] = (SHW'(i) < shift);
    end
endmodule

// File: rtl/pig_event_det.sv
// Fires on a tick whose post-increment count is a multiple of the period.
// Assumes mask holds the low-order ones of the period minus one.
module pig_event_det #(
    parameter int CNT_W = 15
) (
    input  logic             tick_en,
    input  logic             active,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] mask,
    output logic             fire
);
    logic [CNT_W-1:0] nxt;

    // Compare the next count against the period boundary.
    always_comb begin
        nxt  = count + CNT_W'(1);
        fire = tick_en && active && ((nxt & mask) == '0);
    end
endmodule

// File: rtl/pig_status_flags.sv
// Sticky periodic and request flags. Set on an event, cleared by a read.
// A set in the same cycle as a read wins.
module pig_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic rd_clr,
    output logic pf,
    output logic irqf
);
    // Update both flags: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf   <= 1'b0;
            irqf <= 1'b0;
        end else if (fire) begin
            pf   <= 1'b1;
            irqf <= 1'b1;
        end else if (rd_clr) begin
            pf   <= 1'b0;
            irqf <= 1'b0;
        end
    end

    // R8 R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pf && irqf);
    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !fire) |=> !pf && !irqf);
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !fire) |=> $stable(pf) && $stable(irqf));
endmodule

// File: rtl/periodic_irq_gen.sv
// Top of the periodic interrupt generator: free counter, rate map,
// boundary detector and sticky status flags. Assumes tick_32k is a
// one-cycle enable, and that rate_code and periodic_en come from registers.
module periodic_irq_gen
    import periodic_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              periodic_en,
    input  logic              status_rd,
    output logic              irq,
    output logic              irq_flag,
    output logic              periodic_flag
);
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] mask;
    logic             active;
    logic             fire;

    pig_free_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_32k), .count(count)
    );

    pig_rate_map #(.CW(CNT_W), .RW(RATE_W)) u_map (
        .code(rate_code), .enable(periodic_en), .active(active), .mask(mask)
    );

    pig_event_det #(.CNT_W(CNT_W)) u_det (
        .tick_en(tick_32k), .active(active), .count(count), .mask(mask), .fire(fire)
    );

    pig_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .fire(fire), .rd_clr(status_rd),
        .pf(periodic_flag), .irqf(irq_flag)
    );

    // Drive the request line from the combined flag.
    always_comb irq = irq_flag;

    // R5 R6
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == '0 || !periodic_en) |-> !fire);
    // R7
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> tick_32k);
endmodule

// File: tb/periodic_irq_gen_bench.sv
module periodic_irq_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic       rd = 1'b0;
    logic [3:0] code = 4'd0;
    logic       irq, irq_flag, per_flag;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    int ev_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    periodic_irq_gen u_periodic_irq_gen (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick), .rate_code(code),
        .periodic_en(en), .status_rd(rd), .irq(irq),
        .irq_flag(irq_flag), .periodic_flag(per_flag)
    );

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int period_of(logic [3:0] c);
        int e;
        e = int'(c);
        if (c == 4'd1) e = 8;
        else if (c == 4'd2) e = 9;
        return 1 << (e - 1);
    endfunction

    function automatic bit expect_event();
        if (!en || code == 4'd0) return 1'b0;
        return (ref_cnt % period_of(code)) == 0;
    endfunction

    task automatic pulse_tick(output bit ev);
        @(negedge clk) tick = 1'b1;
        ref_cnt = (ref_cnt + 1) % 32768;
        ev = expect_event();
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
    endtask

    task automatic tick_check(string req);
        bit ev;
        pulse_tick(ev);
        chk(req, per_flag, ev, "periodic_flag");
        chk(req, irq_flag, ev, "irq_flag");
        chk(req, irq, ev, "irq");
        if (ev) begin
            ev_seen++;
            do_read();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ref_cnt = 0;
        @(negedge clk);
        chk("R1", irq, 1'b0, "irq after reset");
        chk("R1", irq_flag, 1'b0, "irq_flag after reset");
        chk("R1", per_flag, 1'b0, "periodic_flag after reset");
    endtask

    task automatic t_period();
        en = 1'b1; code = 4'd3; ev_seen = 0;
        for (int i = 0; i < 20; i++) tick_check("R3");
        chk_int("R3", ev_seen, 5, "events in 20 ticks at code 3");
        code = 4'd6; ev_seen = 0;
        for (int i = 0; i < 64; i++) tick_check("R3");
        chk_int("R3", ev_seen, 2, "events in 64 ticks at code 6");
    endtask

    task automatic t_remap();
        code = 4'd1; ev_seen = 0;
        for (int i = 0; i < 256; i++) tick_check("R4");
        chk_int("R4", ev_seen, 2, "events in 256 ticks at code 1");
        code = 4'd2; ev_seen = 0;
        for (int i = 0; i < 512; i++) tick_check("R4");
        chk_int("R4", ev_seen, 2, "events in 512 ticks at code 2");
    endtask

    task automatic t_code_zero();
        code = 4'd0; en = 1'b1;
        for (int i = 0; i < 40; i++) tick_check("R5");
    endtask

    task automatic t_disabled();
        en = 1'b0; code = 4'd3;
        for (int i = 0; i < 41; i++) tick_check("R6");
        en = 1'b1; ev_seen = 0;
        for (int i = 0; i < 8; i++) tick_check("R6");
        chk_int("R6", ev_seen, 2, "events after re-enable");
    endtask

    task automatic t_rate_change();
        code = 4'd5;
        for (int i = 0; i < 5; i++) tick_check("R7");
        code = 4'd4;
        for (int i = 0; i < 20; i++) tick_check("R7");
        code = 4'd3;
        for (int i = 0; i < 6; i++) tick_check("R7");
    endtask

    task automatic t_latency();
        bit ev;
        code = 4'd3;
        while (((ref_cnt + 1) % 4) != 0) tick_check("R8");
        @(negedge clk) tick = 1'b1;
        ref_cnt = (ref_cnt + 1) % 32768;
        #1;
        chk("R8", per_flag, 1'b0, "flag before sampling edge");
        @(negedge clk) tick = 1'b0;
        chk("R8", per_flag, 1'b1, "flag one edge after tick");
        chk("R8", irq, 1'b1, "irq one edge after tick");
        for (int i = 0; i < 3; i++) begin
            pulse_tick(ev);
            chk("R9", per_flag, 1'b1, "periodic_flag stays set");
            chk("R9", irq, 1'b1, "irq stays set");
        end
        do_read();
        chk("R9", per_flag, 1'b0, "periodic_flag after read");
        chk("R9", irq_flag, 1'b0, "irq_flag after read");
        chk("R9", irq, 1'b0, "irq after read");
    endtask

    task automatic t_collide();
        code = 4'd3;
        while (((ref_cnt + 1) % 4) != 0) tick_check("R10");
        @(negedge clk) begin tick = 1'b1; rd = 1'b1; end
        ref_cnt = (ref_cnt + 1) % 32768;
        @(negedge clk) begin tick = 1'b0; rd = 1'b0; end
        chk("R10", per_flag, 1'b1, "periodic_flag on set+read");
        chk("R10", irq_flag, 1'b1, "irq_flag on set+read");
        do_read();
        chk("R10", irq, 1'b0, "irq after later read");
    endtask

    task automatic t_wrap();
        code = 4'd15; ev_seen = 0;
        for (int i = 0; i < 32768; i++) tick_check("R2");
        chk_int("R2", ev_seen, 2, "events over one full counter cycle");
    endtask

    initial begin
        t_reset();
        t_period();
        t_remap();
        t_code_zero();
        t_disabled();
        t_rate_change();
        t_latency();
        t_collide();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule